// File: doc/BRIEF.md
# Reset-Cause Status Register

This block holds an 8-bit, read-only status word. Software reads it after reset to find out two things: whether the last reset came from the power-on detector, and whether the supply rail has dropped below the low-voltage threshold since the word was last read. Bit 0 is the power-on flag. Bit 1 is the low-supply flag. Bits 7 to 2 always read as zero.

The power-on detector drives an asynchronous active-low reset. While that reset is asserted, both flags are forced to 1. The external pin reset is a second reset domain. It resets the synchronizers and the read path, but it never touches the flags, so the cause of a reset survives a pin reset. The comparator output is asynchronous and passes through a two-flop synchronizer before it can set the low-supply flag. Once set, that flag stays set. A bus read hit returns the current word in the same cycle, and both flags clear on the clock edge that ends the read. A set from the synchronizer in that same cycle takes priority over the clear.

Top module: `rcs_status_reg`

## Requirements
- R1: While `por_n` is low, and after it is released, the word reads 0x03 (bit 0 = power-on flag = 1, bit 1 = low-supply flag = 1). No event other than `por_n` ever sets bit 0.
- R2: A low level on `pin_rst_n` leaves both flags unchanged, and a read hit while the pin reset is asserted does not clear them.
- R3: When `lvd_async` goes high, `lv_flag` (bit 1) rises on the third rising edge of `clk` after the change, and not on any earlier edge.
- R4: Once set, `lv_flag` stays at 1 after `lvd_async` falls, until a read clears it.
- R5: In a cycle with `sel` and `rd_en` both high, `rd_data` equals {6'b0, lv_flag, por_flag}, taken before the clear. Bits 7:2 are always 0.
- R6: A read hit outside pin reset clears both flags on the rising edge that ends the read cycle.
- R7: If the synchronized low-voltage flag is high on the same edge that a read clears the word, bit 1 stays 1.
- R8: A cycle with `sel` and `wr_en` high and `rd_en` low leaves the word unchanged.
- R9: `rd_en` without `sel` returns `rd_data` = 0 and does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on-clear reset from the detector, active low, asynchronous |
| pin_rst_n | input | 1 | External pin reset, active low, asynchronous |
| lvd_async | input | 1 | Low-supply comparator output, asynchronous |
| sel | input | 1 | Address decode hit for this register |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe (has no effect) |
| rd_data | output | 8 | Read data, zero when there is no read hit |
| por_flag | output | 1 | Power-on flag (bit 0) |
| lv_flag | output | 1 | Low-supply flag (bit 1) |

## Verification
Read data is combinational, so it is due in the read cycle itself. The scoreboard monitor samples it at the falling edge of that cycle. The driver asserts the strobes 1 ns after a rising edge, which places each read inside exactly one clock period. The clear, and any effect of a write or a pin reset, shows up after the next rising edge. The driver samples the flag outputs 1 ns after that edge. For the low-supply flag, the bench samples after the second edge, where the flag must still be 0, and after the third edge, where it must be 1.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int RCS_DATA_W      = 8;
  localparam int RCS_STAT_W      = 2;
  localparam int RCS_SYNC_STAGES = 2;

  typedef enum int {
    RCS_BIT_POR = 0,
    RCS_BIT_LV  = 1
  } rcs_bit_e;
endpackage

// File: rtl/rcs_reset_sync.sv
module rcs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rcs_bit_sync.sv
module rcs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_lat_chk
      // a synchronized high must come from the input sampled two edges earlier
      AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        q_o |-> $past(d_i, 2)); // R3
    end
  endgenerate
endmodule

// File: rtl/rcs_sticky_bit.sv
module rcs_sticky_bit (
  input  logic clk,
  input  logic preset_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic en;

  always_comb begin
    en  = set_i | clr_i;
    q_d = set_i | (q_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n) q_q <= 1'b1;
    else if (en)   q_q <= q_d;
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!preset_n)
    set_i |=> q_o); // R7
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!preset_n)
    (clr_i && !set_i) |=> !q_o); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!preset_n)
    (q_o && !clr_i) |=> q_o); // R4
endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
  import rcs_pkg::*;
#(
  parameter int SYNC_STAGES = RCS_SYNC_STAGES,
  parameter int DATA_W      = RCS_DATA_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_rst_n,
  input  logic              lvd_async,
  input  logic              sel,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              por_flag,
  output logic              lv_flag
);
  localparam int STAT_W = RCS_STAT_W;

  logic              por_rst_n;
  logic              sys_rst_n;
  logic              sys_arst_n;
  logic              lv_set;
  logic              rd_hit;
  logic              clr;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] status;

  assign sys_arst_n = por_n & pin_rst_n;

  rcs_reset_sync #(.STAGES(SYNC_STAGES)) i_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .rst_n  (por_rst_n)
  );

  rcs_reset_sync #(.STAGES(SYNC_STAGES)) i_sys_sync (
    .clk    (clk),
    .arst_n (sys_arst_n),
    .rst_n  (sys_rst_n)
  );

  rcs_bit_sync #(.STAGES(SYNC_STAGES)) i_lvd_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d_i   (lvd_async),
    .q_o   (lv_set)
  );

  always_comb begin
    rd_hit                = sel & rd_en;
    clr                   = rd_hit & sys_rst_n;
    set_vec               = '0;
    set_vec[RCS_BIT_LV]   = lv_set;
  end

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      rcs_sticky_bit i_bit (
        .clk      (clk),
        .preset_n (por_rst_n),
        .set_i    (set_vec[i]),
        .clr_i    (clr),
        .q_o      (status[i])
      );
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data[STAT_W-1:0] = status;
  end

  assign por_flag = status[RCS_BIT_POR];
  assign lv_flag  = status[RCS_BIT_LV];

  AST_POR_ONLY_SOURCE: assert property (@(posedge clk) disable iff (!por_rst_n)
    !$rose(por_flag)); // R1
  AST_PIN_RST_KEEP: assert property (@(posedge clk) disable iff (!por_rst_n)
    !sys_rst_n |=> ((status & $past(status)) == $past(status))); // R2
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_rst_n)
    (sel && wr_en && !rd_en && !lv_set) |=> (status == $past(status))); // R8
  AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!rd_hit && !lv_set) |=> (status == $past(status))); // R9
endmodule

// File: tb/test_rcs_status_reg.sv
`timescale 1ns/1ps
module test_rcs_status_reg;
  logic       clk = 1'b0;
  logic       por_n, pin_rst_n, lvd_async, sel, rd_en, wr_en;
  logic [7:0] rd_data;
  logic       por_flag, lv_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  rcs_status_reg i_rcs_status_reg (
    .clk       (clk),
    .por_n     (por_n),
    .pin_rst_n (pin_rst_n),
    .lvd_async (lvd_async),
    .sel       (sel),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .por_flag  (por_flag),
    .lv_flag   (lv_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // driver: one read cycle, expected data pushed for the monitor
  task automatic do_read(input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    sel = 1'b1; rd_en = 1'b1;
    tick(1);
    sel = 1'b0; rd_en = 1'b0;
  endtask

  // monitor: compare read data in the middle of each read cycle
  always @(negedge clk) begin
    if (sel && rd_en) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5: unexpected read 0x%02h expected none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; pin_rst_n = 1'b1; lvd_async = 1'b0;
    sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    tick(2);
    chk("R1 flags during por", {6'b0, lv_flag, por_flag}, 8'h03);
    por_n = 1'b1;
    tick(4);
    chk("R1 flags after por", {6'b0, lv_flag, por_flag}, 8'h03);
    do_read(8'h03, "R1 R5 read after por");
    chk("R6 cleared by read", {6'b0, lv_flag, por_flag}, 8'h00);

    // R3 synchronizer latency
    lvd_async = 1'b1;
    tick(2);
    chk("R3 not yet after two edges", {7'b0, lv_flag}, 8'h00);
    tick(1);
    chk("R3 set on third edge", {7'b0, lv_flag}, 8'h01);
    lvd_async = 1'b0;
    tick(5);
    chk("R4 sticky after recovery", {7'b0, lv_flag}, 8'h01);

    // R9 read strobe without select
    rd_en = 1'b1;
    #1 chk("R9 no-select data", rd_data, 8'h00);
    tick(1);
    rd_en = 1'b0;
    chk("R9 no-select keeps flag", {6'b0, lv_flag, por_flag}, 8'h02);

    // R8 write ignored
    sel = 1'b1; wr_en = 1'b1;
    tick(1);
    sel = 1'b0; wr_en = 1'b0;
    chk("R8 write ignored", {6'b0, lv_flag, por_flag}, 8'h02);

    // R2 pin reset keeps flags, read under pin reset does not clear
    pin_rst_n = 1'b0;
    tick(1);
    do_read(8'h02, "R2 read during pin reset");
    tick(1);
    pin_rst_n = 1'b1;
    tick(3);
    chk("R2 flags kept across pin reset", {6'b0, lv_flag, por_flag}, 8'h02);
    do_read(8'h02, "R5 read after pin reset");
    chk("R6 cleared after read", {6'b0, lv_flag, por_flag}, 8'h00);

    // R7 set wins over clear
    lvd_async = 1'b1;
    tick(4);
    do_read(8'h02, "R7 read while low supply");
    chk("R7 set beats clear", {7'b0, lv_flag}, 8'h01);
    do_read(8'h02, "R7 second read");
    lvd_async = 1'b0;
    tick(4);
    do_read(8'h02, "R4 read after recovery");
    chk("R6 clear after recovery", {6'b0, lv_flag, por_flag}, 8'h00);
    do_read(8'h00, "R5 empty word");

    // R1 second power-on event mid-run
    por_n = 1'b0;
    #1 chk("R1 async preset", {6'b0, lv_flag, por_flag}, 8'h03);
    tick(2);
    por_n = 1'b1;
    tick(4);
    do_read(8'h03, "R1 read after second por");
    tick(2);
    chk("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule